// File: doc/BRIEF.md
# Predicated Status Flags and Condition Evaluator

This block keeps the four processor status flags (negative, zero, carry, overflow) in a clocked register. It decides, every cycle, whether the instruction now in flight may take effect. The instruction supplies a 4-bit condition code, and the block tests that code against the flags held in the register. The resulting pass signal is used elsewhere to gate register writeback, memory stores and branch redirection.

The flags are rewritten from the arithmetic unit's flag outputs only when two things are true: the instruction asks for a flag update, and its own condition passes. An instruction whose condition fails therefore has no side effect of any kind, flags included. The pass decision always uses the flags registered at the start of the cycle. A compare instruction therefore affects the instructions that follow it, but never the compare itself.

Top module: `cc_status_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, the flag register becomes 0000 on that edge.
- R2: At a rising edge where `flag_update_en` and `cond_pass` are both 1, `flags_q` takes the value of `alu_flags`. Bit order in both is [3]=N, [2]=Z, [1]=C, [0]=V.
- R3: At a rising edge where `flag_update_en` is 0, `flags_q` keeps its value.
- R4: At a rising edge where `cond_pass` is 0, `flags_q` keeps its value even when `flag_update_en` is 1.
- R5: Code 0000 passes when Z=1 and code 0001 passes when Z=0. Code 0100 passes when N=1 and code 0101 passes when N=0.
- R6: Code 0010 passes when C=1 and code 0011 passes when C=0. Code 0110 passes when V=1 and code 0111 passes when V=0.
- R7: Code 1000 passes when C=1 and Z=0. Code 1001 passes exactly when 1000 would not.
- R8: Code 1010 passes when N equals V, and code 1011 when they differ. Code 1100 passes when Z=0 and N equals V, and code 1101 passes exactly when 1100 would not.
- R9: Codes 1110 and 1111 always pass.
- R10: `cond_pass` depends only on `cond_code` and the registered flags. It never depends on `alu_flags` presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_code | input | 4 | Condition carried by the current instruction |
| flag_update_en | input | 1 | Current instruction requests a flag write |
| alu_flags | input | 4 | Flags produced by the arithmetic unit, {N,Z,C,V} |
| cond_pass | output | 1 | Current instruction may take effect |
| flags_q | output | 4 | Registered flags, {N,Z,C,V} |

## Verification
The bench loads each of the 16 flag patterns and then sweeps all 16 condition codes over each one. This catches any swapped flag bit or inverted code pair, which would show up as a code passing on the wrong pattern. It sends a flag update under a failing condition; a design that ignored the suppression would overwrite the flags. It also offers new flags in the same cycle as a condition that depends on them; a design that bypassed the register would let the compare affect its own condition. Two instruction sequences are replayed: a subtraction giving a negative result, and a decrement loop that exits on zero. Both confirm that a following instruction sees the flags its predecessor produced.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int FLAG_W = 4;
  localparam int COND_W = 4;

  typedef enum logic [COND_W-1:0] {
    COND_EQ  = 4'b0000,
    COND_NE  = 4'b0001,
    COND_CS  = 4'b0010,
    COND_CC  = 4'b0011,
    COND_MI  = 4'b0100,
    COND_PL  = 4'b0101,
    COND_VS  = 4'b0110,
    COND_VC  = 4'b0111,
    COND_HI  = 4'b1000,
    COND_LS  = 4'b1001,
    COND_GE  = 4'b1010,
    COND_LT  = 4'b1011,
    COND_GT  = 4'b1100,
    COND_LE  = 4'b1101,
    COND_AL  = 4'b1110,
    COND_RSV = 4'b1111
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/cc_flag_reg.sv
module cc_flag_reg #(
  parameter int W = cc_pkg::FLAG_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end

  // R1: reset empties the register
  assert_reset_clear_R1: assert property (@(posedge clk) rst |=> q == '0);
  // R3/R4: no load means no change
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !load |=> q == $past(q));
endmodule

// File: rtl/cc_cond_eval.sv
module cc_cond_eval
  import cc_pkg::*;
(
  input  logic [COND_W-1:0] cond,
  input  flags_t            f,
  output logic              pass
);
  logic n_eq_v;
  assign n_eq_v = (f.n == f.v);

  always_comb begin
    case (cond_e'(cond))
      COND_EQ:  pass = f.z;
      COND_NE:  pass = !f.z;
      COND_CS:  pass = f.c;
      COND_CC:  pass = !f.c;
      COND_MI:  pass = f.n;
      COND_PL:  pass = !f.n;
      COND_VS:  pass = f.v;
      COND_VC:  pass = !f.v;
      COND_HI:  pass = f.c && !f.z;
      COND_LS:  pass = !f.c || f.z;
      COND_GE:  pass = n_eq_v;
      COND_LT:  pass = !n_eq_v;
      COND_GT:  pass = !f.z && n_eq_v;
      COND_LE:  pass = f.z || !n_eq_v;
      default:  pass = 1'b1;
    endcase
  end
endmodule

// File: rtl/cc_status_unit.sv
module cc_status_unit
  import cc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [COND_W-1:0] cond_code,
  input  logic              flag_update_en,
  input  logic [FLAG_W-1:0] alu_flags,
  output logic              cond_pass,
  output logic [FLAG_W-1:0] flags_q
);
  logic   do_load;
  flags_t cur_flags;

  assign cur_flags = flags_t'(flags_q);

  cc_cond_eval u_eval (
    .cond (cond_code),
    .f    (cur_flags),
    .pass (cond_pass)
  );

  assign do_load = flag_update_en && cond_pass;

  cc_flag_reg #(.W(FLAG_W)) u_flags (
    .clk  (clk),
    .rst  (rst),
    .load (do_load),
    .d    (alu_flags),
    .q    (flags_q)
  );

  // R2: a permitted update captures the offered flags
  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    (flag_update_en && cond_pass) |=> flags_q == $past(alu_flags));
  // R4: a failed condition never alters the flags
  assert_suppress_R4: assert property (@(posedge clk) disable iff (rst)
    !cond_pass |=> flags_q == $past(flags_q));
  // R5: the equal code follows the registered zero flag
  assert_eq_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (cond_code == 4'b0000) |-> cond_pass == flags_q[2]);
  // R9: the always codes pass
  assert_always_R9: assert property (@(posedge clk) disable iff (rst)
    (cond_code[3:1] == 3'b111) |-> cond_pass);
endmodule

// File: tb/sim_cc_status_unit.sv
`timescale 1ns/1ps
module sim_cc_status_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] cond_code = 4'b1110;
  logic       flag_update_en = 1'b0;
  logic [3:0] alu_flags = 4'b0000;
  logic       cond_pass;
  logic [3:0] flags_q;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [3:0] mflags = 4'b0000;

  always #2.5 clk = ~clk;

  cc_status_unit u0 (
    .clk(clk), .rst(rst), .cond_code(cond_code),
    .flag_update_en(flag_update_en), .alu_flags(alu_flags),
    .cond_pass(cond_pass), .flags_q(flags_q)
  );

  function automatic bit ref_pass(input int code, input logic [3:0] fl);
    int n = fl[3]; int z = fl[2]; int c = fl[1]; int v = fl[0];
    case (code)
      0: return z == 1;             1: return z == 0;
      2: return c == 1;             3: return c == 0;
      4: return n == 1;             5: return n == 0;
      6: return v == 1;             7: return v == 0;
      8: return c == 1 && z == 0;   9: return !(c == 1 && z == 0);
      10: return n == v;            11: return n != v;
      12: return z == 0 && n == v;  13: return !(z == 0 && n == v);
      default: return 1'b1;
    endcase
  endfunction

  function automatic string tag_of(input int code);
    if (code < 2 || code == 4 || code == 5) return "R5";
    if (code < 8) return "R6";
    if (code < 10) return "R7";
    if (code < 14) return "R8";
    return "R9";
  endfunction

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at cycle %0d", req, got, exp, cycles);
    end
  endtask

  // behavioural reference, updated on every edge
  always @(posedge clk) begin
    cycles++;
    if (rst) mflags <= 4'b0000;
    else if (flag_update_en && ref_pass(int'(cond_code), mflags)) mflags <= alu_flags;
  end

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (!rst) begin
      check("R2/R3/R4 flags", int'(flags_q), int'(mflags));
      check({tag_of(int'(cond_code)), " pass/R10"}, int'(cond_pass),
            int'(ref_pass(int'(cond_code), mflags)));
    end
  end

  task automatic drive(input int code, input bit upd, input logic [3:0] fl);
    @(posedge clk); #1;
    cond_code = 4'(code);
    flag_update_en = upd;
    alu_flags = fl;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    alu_flags = 4'b1111;
    flag_update_en = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset flags", int'(flags_q), 0);
    rst = 1'b0;

    // R9: both always codes pass from the cleared state
    drive(14, 0, 4'b0000); @(negedge clk); check("R9 code 1110", int'(cond_pass), 1);
    drive(15, 0, 4'b0000); @(negedge clk); check("R9 code 1111", int'(cond_pass), 1);

    // sweep every flag pattern against every code: R5 R6 R7 R8 R9
    for (int f = 0; f < 16; f++) begin
      drive(14, 1, 4'(f));
      drive(14, 0, 4'b0000);
      @(negedge clk); check("R2 load", int'(flags_q), f);
      for (int c = 0; c < 16; c++) begin
        drive(c, 0, 4'(15 - f));
        @(negedge clk);
        check(tag_of(c), int'(cond_pass), int'(ref_pass(c, 4'(f))));
      end
      check("R3 hold after sweep", int'(flags_q), f);
    end

    // compare 17-23: N=1 Z=0 C=0 V=0
    drive(14, 1, 4'b1000);
    drive(0, 0, 4'b0000); @(negedge clk); check("R5 EQ after 17-23", int'(cond_pass), 0);
    drive(4, 0, 4'b0000); @(negedge clk); check("R5 MI after 17-23", int'(cond_pass), 1);

    // R4: failing EQ with update requested must not write
    drive(0, 1, 4'b0110); @(negedge clk); check("R4 fail pass", int'(cond_pass), 0);
    drive(14, 0, 4'b0000); @(negedge clk); check("R4 flags kept", int'(flags_q), 8);

    // R10: flags offered in the same cycle do not steer the condition
    drive(0, 1, 4'b0100); @(negedge clk); check("R10 same-cycle Z ignored", int'(cond_pass), 0);
    drive(14, 0, 4'b0000); @(negedge clk); check("R10 flags kept", int'(flags_q), 8);
    drive(4, 1, 4'b0100); @(negedge clk); check("R10 MI old N", int'(cond_pass), 1);
    drive(0, 0, 4'b0000); @(negedge clk); check("R10 next sees Z", int'(cond_pass), 1);

    // countdown loop: decrement setting flags, repeat on NE
    begin
      int cnt = 5;
      int iters = 0;
      bit again = 1'b1;
      while (again) begin
        cnt--; iters++;
        drive(14, 1, {1'b0, cnt == 0, 1'b1, 1'b0});
        drive(1, 0, 4'b0000);
        @(negedge clk);
        again = cond_pass;
        check("R5 NE loop", int'(cond_pass), int'(cnt != 0));
        if (iters > 10) again = 1'b0;
      end
      check("R5 loop count", iters, 5);
    end

    // R1: reset mid-run clears the flags
    drive(14, 1, 4'b1111);
    @(posedge clk); #1; rst = 1'b1;
    @(posedge clk); #1;
    check("R1 mid-run reset", int'(flags_q), 0);
    rst = 1'b0;
    drive(14, 0, 4'b0000);
    @(negedge clk);
    finish_run();
  end
endmodule